// File: doc/BRIEF.md
# Four-State Hard-Decision Add-Compare-Select Unit

This block is the forward half of a hard-decision Viterbi decoder for a rate-1/2 convolutional code with memory two. It works on a trellis of four states. Each accepted 2-bit received symbol is compared against the expected code word of all eight trellis branches. The comparison uses the Hamming distance, and all eight distances are formed in the same cycle. Each state then keeps the cheaper of its two incoming paths. The block reports which predecessor won for every state as a 4-bit decision vector, with a valid strobe and the index of the trellis step.

The decision vectors are meant for a survivor store and a traceback stage downstream. A `start` pulse opens a message, and decoding always begins from the all-zero encoder state, which assumes the sender ends each message with zero tail bits. Path metrics are kept in narrow registers. When the smallest metric passes a threshold, that minimum is subtracted from all four, so every comparison comes out as it would with unbounded metrics.

A two-state controller sequences the block:
- `CTL_IDLE` is the state after reset. Symbols are ignored here, and the transition `IDLE->RUN` is taken on `start`.
- `CTL_RUN` accepts one symbol per valid cycle. It stays in `RUN`, and a `start` seen in `RUN` takes the restart transition `RUN->RUN`, which reloads the initial metrics.

Top module: `trellis_acs4`

## Requirements
- R1: After reset, `running`, `dec_valid`, `step` and `dec` are all zero.
- R2: When `start` is high at a rising edge, `running` is 1 from the next cycle on and `step` reads 0. The first decision after that start carries step index 0.
- R3: A symbol is accepted only when the block is running, `sym_valid` is high and `start` is low. Each accepted symbol gives exactly one cycle of `dec_valid` after the edge that takes it. Symbols offered while idle, or in the same cycle as `start`, change neither the outputs nor the metrics.
- R4: The branch metric is the Hamming distance between `sym` and the branch word. For encoder state s = {s1,s0} (s1 is the newest input) and input bit u, the branch word is `sym[1]` = u^s1^s0 (generator 7 octal) and `sym[0]` = u^s0 (generator 5 octal). The next state is {u,s1}.
- R5: Bit n of `dec` belongs to next state n. That state's upper predecessor is {n[0],0} and its lower predecessor is {n[0],1}. The bit is 0 when the upper path's metric plus branch metric is less than or equal to the lower one's, and 1 otherwise, so a tie gives 0.
- R6: A start sets the metric of state 0 to 0 and the metrics of the other three states to `INIT_BIG` (default 64). Decoding therefore begins from the all-zero state.
- R7: The minimum is subtracted from all four metrics whenever, after an update, the minimum exceeds `NORM_TH`. Because of this, decisions on arbitrarily long noisy streams equal those of unbounded arithmetic, and no metric gets near the top of its range.
- R8: Successive decisions carry step indices that rise by one and wrap at 2^`STEP_W`. Cycles without a symbol do not advance the index.
- R9: A `start` while running restarts the message: metrics are reinitialised and the step index returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin (or restart) a message from the zero state |
| sym_valid | input | 1 | `sym` carries a received symbol this cycle |
| sym | input | 2 | Received hard symbol, bit 1 = generator 7, bit 0 = generator 5 |
| dec | output | 4 | Decision vector, bit n for next state n |
| dec_valid | output | 1 | `dec` and `step` hold a new decision |
| step | output | STEP_W | Trellis step index of the current decision |
| running | output | 1 | Controller is in the run state |

## Verification
The bench targets the start-up metrics. A block that opened with all metrics equal would report a decision of 1 for state 0 on the first `11` symbol. It also targets the tie rule: picking the lower branch on ties turns the first-step vector for symbol `00` from 0000 into 1010. A long stream of random symbols drives the reference minimum well past the register range, so a block that failed to subtract the minimum, or subtracted it wrongly, would wrap a metric and flip decisions against the bench's unbounded model. A symbol offered together with `start` or while idle is followed by fresh-message decisions. These would be offset by one trellis step if the symbol had been absorbed. Gaps in `sym_valid` and index wrap at a reduced `STEP_W` catch a counter that advances on idle cycles.

// File: rtl/trellis_pkg.sv
package trellis_pkg;

    localparam int NUM_ST = 4;
    localparam int ST_W   = 2;
    localparam int SYM_W  = 2;
    localparam int BM_W   = 2;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_state_t;

    // Expected code word on the branch leaving state st with input u.
    // Bit 1 follows generator 7 (octal), bit 0 follows generator 5 (octal).
    function automatic logic [SYM_W-1:0] branch_word(input logic [ST_W-1:0] st,
                                                     input logic u);
        return {u ^ st[1] ^ st[0], u ^ st[0]};
    endfunction

    // Hamming weight of a 2-bit difference.
    function automatic logic [BM_W-1:0] weight2(input logic [SYM_W-1:0] x);
        return {1'b0, x[1]} + {1'b0, x[0]};
    endfunction

endpackage

// File: rtl/trellis_bmu.sv
module trellis_bmu
    import trellis_pkg::*;
(
    input  logic [SYM_W-1:0]             sym,
    output logic [NUM_ST-1:0][BM_W-1:0]  bm_up,
    output logic [NUM_ST-1:0][BM_W-1:0]  bm_lo
);

    // For next state n = {u, a}: predecessors {a,0} (upper) and {a,1} (lower).
    for (genvar n = 0; n < NUM_ST; n++) begin : g_branch
        localparam logic [ST_W-1:0] NXT = ST_W'(n);
        localparam logic [ST_W-1:0] PUP = {NXT[0], 1'b0};
        localparam logic [ST_W-1:0] PLO = {NXT[0], 1'b1};

        assign bm_up[n] = weight2(sym ^ branch_word(PUP, NXT[1]));
        assign bm_lo[n] = weight2(sym ^ branch_word(PLO, NXT[1]));
    end

endmodule

// File: rtl/trellis_acs_node.sv
module trellis_acs_node
    import trellis_pkg::*;
#(
    parameter int PM_W = 8
) (
    input  logic [PM_W-1:0] pm_up,
    input  logic [PM_W-1:0] pm_lo,
    input  logic [BM_W-1:0] bm_up,
    input  logic [BM_W-1:0] bm_lo,
    output logic [PM_W-1:0] pm_new,
    output logic            pick_lo
);

    logic [PM_W-1:0] cand_up;
    logic [PM_W-1:0] cand_lo;

    always_comb begin
        cand_up = pm_up + PM_W'(bm_up);
        cand_lo = pm_lo + PM_W'(bm_lo);
        // strict compare: an equal pair keeps the upper branch
        pick_lo = (cand_lo < cand_up);
        pm_new  = pick_lo ? cand_lo : cand_up;
    end

endmodule

// File: rtl/trellis_ctrl.sv
module trellis_ctrl
    import trellis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sym_valid,
    output logic running,
    output logic load_init,
    output logic take_sym
);

    ctl_state_t st_q;
    ctl_state_t st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CTL_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CTL_IDLE: if (start) st_d = CTL_RUN;   // IDLE->RUN
            CTL_RUN:  st_d = CTL_RUN;              // RUN->RUN, restart on start
            default:  st_d = CTL_IDLE;
        endcase
    end

    always_comb begin
        running   = 1'b0;
        load_init = start;
        take_sym  = 1'b0;
        unique case (st_q)
            CTL_IDLE: begin
                running  = 1'b0;
                take_sym = 1'b0;
            end
            CTL_RUN: begin
                running  = 1'b1;
                take_sym = sym_valid && !start;
            end
            default: begin
                running  = 1'b0;
                take_sym = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/trellis_acs4.sv
module trellis_acs4
    import trellis_pkg::*;
#(
    parameter int PM_W     = 8,
    parameter int STEP_W   = 16,
    parameter int INIT_BIG = 64,
    parameter int NORM_TH  = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  sym_valid,
    input  logic [SYM_W-1:0]      sym,
    output logic [NUM_ST-1:0]     dec,
    output logic                  dec_valid,
    output logic [STEP_W-1:0]     step,
    output logic                  running
);

    localparam logic [PM_W-1:0] PM_BIG = PM_W'(INIT_BIG);
    localparam logic [PM_W-1:0] PM_TH  = PM_W'(NORM_TH);

    logic load_init;
    logic take_sym;

    logic [NUM_ST-1:0][PM_W-1:0] pm_q;
    logic [NUM_ST-1:0][PM_W-1:0] pm_acs;
    logic [NUM_ST-1:0][PM_W-1:0] pm_next;
    logic [NUM_ST-1:0]           pick_lo;
    logic [NUM_ST-1:0][BM_W-1:0] bm_up;
    logic [NUM_ST-1:0][BM_W-1:0] bm_lo;
    logic [PM_W-1:0]             pm_min;
    logic [STEP_W-1:0]           step_ctr;
    logic [NUM_ST-1:0]           dec_q;
    logic                        dec_valid_q;
    logic [STEP_W-1:0]           step_q;

    trellis_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .sym_valid (sym_valid),
        .running   (running),
        .load_init (load_init),
        .take_sym  (take_sym)
    );

    trellis_bmu u_bmu (
        .sym   (sym),
        .bm_up (bm_up),
        .bm_lo (bm_lo)
    );

    for (genvar n = 0; n < NUM_ST; n++) begin : g_acs
        localparam logic [ST_W-1:0] NXT = ST_W'(n);
        localparam int PUP = int'({NXT[0], 1'b0});
        localparam int PLO = int'({NXT[0], 1'b1});

        trellis_acs_node #(.PM_W(PM_W)) u_node (
            .pm_up   (pm_q[PUP]),
            .pm_lo   (pm_q[PLO]),
            .bm_up   (bm_up[n]),
            .bm_lo   (bm_lo[n]),
            .pm_new  (pm_acs[n]),
            .pick_lo (pick_lo[n])
        );
    end

    // rescale when the best metric climbs past the threshold
    always_comb begin
        pm_min = pm_acs[0];
        for (int i = 1; i < NUM_ST; i++) begin
            if (pm_acs[i] < pm_min) pm_min = pm_acs[i];
        end
        for (int i = 0; i < NUM_ST; i++) begin
            pm_next[i] = (pm_min > PM_TH) ? (pm_acs[i] - pm_min) : pm_acs[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_q        <= '0;
            step_ctr    <= '0;
            dec_q       <= '0;
            dec_valid_q <= 1'b0;
            step_q      <= '0;
        end else if (load_init) begin
            for (int i = 0; i < NUM_ST; i++) begin
                pm_q[i] <= (i == 0) ? '0 : PM_BIG;
            end
            step_ctr    <= '0;
            step_q      <= '0;
            dec_valid_q <= 1'b0;
        end else if (take_sym) begin
            pm_q        <= pm_next;
            dec_q       <= pick_lo;
            dec_valid_q <= 1'b1;
            step_q      <= step_ctr;
            step_ctr    <= step_ctr + 1'b1;
        end else begin
            dec_valid_q <= 1'b0;
        end
    end

    assign dec       = dec_q;
    assign dec_valid = dec_valid_q;
    assign step      = step_q;

endmodule

// File: rtl/trellis_acs4_chk.sv
module trellis_acs4_chk #(
    parameter int PM_W   = 8,
    parameter int STEP_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 sym_valid,
    input logic                 dec_valid,
    input logic [STEP_W-1:0]    step,
    input logic                 running,
    input logic [3:0][PM_W-1:0] pm
);

    localparam logic [PM_W-1:0] PM_SAFE = PM_W'((1 << PM_W) - 4);

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !dec_valid);                                         // R3

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (running && step == '0 && !dec_valid));                 // R2

    AST_VALID_FROM_SYM: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        dec_valid |-> ($past(sym_valid) && !$past(start) && $past(running))); // R3

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (dec_valid && $past(dec_valid)) |-> (step == STEP_W'($past(step) + 1'b1))); // R8

    for (genvar i = 0; i < 4; i++) begin : g_pm
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            pm[i] <= PM_SAFE);                                            // R7
    end

endmodule

bind trellis_acs4 trellis_acs4_chk #(.PM_W(PM_W), .STEP_W(STEP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sym_valid (sym_valid),
    .dec_valid (dec_valid),
    .step      (step),
    .running   (running),
    .pm        (pm_q)
);

// File: tb/trellis_acs4_test.sv
`timescale 1ns/100ps
module trellis_acs4_test;

    localparam int TB_STEP_W = 8;
    localparam int BIG = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       sym_valid = 1'b0;
    logic [1:0] sym = 2'b00;
    logic [3:0] dec;
    logic       dec_valid;
    logic [TB_STEP_W-1:0] step;
    logic       running;

    int vecs = 0;
    int bad  = 0;
    int rpm [4];
    int exp_step = 0;
    logic [1:0] enc_st = 2'b00;
    logic [3:0] last_exp;

    always #2.5 clk = ~clk;

    trellis_acs4 #(.STEP_W(TB_STEP_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .sym_valid (sym_valid),
        .sym       (sym),
        .dec       (dec),
        .dec_valid (dec_valid),
        .step      (step),
        .running   (running)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        vecs++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [1:0] bword(input logic [1:0] st, input logic u);
        return {u ^ st[1] ^ st[0], u ^ st[0]};
    endfunction

    task automatic ref_init();
        rpm[0] = 0; rpm[1] = BIG; rpm[2] = BIG; rpm[3] = BIG;
        exp_step = 0;
    endtask

    task automatic ref_advance(input logic [1:0] s, output logic [3:0] d);
        int nxt [4];
        for (int n = 0; n < 4; n++) begin
            logic u;
            logic [1:0] pu, pl;
            int cu, cl;
            u  = n[1];
            pu = {n[0] != 0, 1'b0};
            pl = {n[0] != 0, 1'b1};
            cu = rpm[pu] + $countones(s ^ bword(pu, u));
            cl = rpm[pl] + $countones(s ^ bword(pl, u));
            d[n]   = (cl < cu);
            nxt[n] = (cl < cu) ? cl : cu;
        end
        for (int n = 0; n < 4; n++) rpm[n] = nxt[n];
    endtask

    function automatic logic [1:0] encode(input logic u);
        logic [1:0] w;
        w = bword(enc_st, u);
        enc_st = {u, enc_st[1]};
        return w;
    endfunction

    task automatic cyc(input logic st, input logic v, input logic [1:0] s);
        start = st; sym_valid = v; sym = s;
        @(negedge clk);
        start = 1'b0; sym_valid = 1'b0;
    endtask

    task automatic feed(input logic [1:0] s, input string req);
        logic [3:0] d;
        ref_advance(s, d);
        last_exp = d;
        cyc(1'b0, 1'b1, s);
        chk(dec_valid == 1'b1, req, "dec_valid", dec_valid, 1);
        chk(dec == d, req, "dec", dec, d);
        chk(step == TB_STEP_W'(exp_step), req, "step", step, exp_step % (1 << TB_STEP_W));
        exp_step++;
    endtask

    task automatic begin_run(input string req);
        cyc(1'b1, 1'b0, 2'b00);
        ref_init();
        chk(running == 1'b1, req, "running after start", running, 1);
        chk(step == '0, req, "step after start", step, 0);
        chk(dec_valid == 1'b0, req, "dec_valid after start", dec_valid, 0);
    endtask

    task automatic t_reset();
        chk(running == 1'b0, "R1", "running", running, 0);
        chk(dec_valid == 1'b0, "R1", "dec_valid", dec_valid, 0);
        chk(step == '0, "R1", "step", step, 0);
        chk(dec == '0, "R1", "dec", dec, 0);
    endtask

    task automatic t_idle_ignored();
        for (int i = 0; i < 4; i++) begin
            cyc(1'b0, 1'b1, 2'(i));
            chk(dec_valid == 1'b0, "R3", "idle dec_valid", dec_valid, 0);
            chk(running == 1'b0, "R3", "idle running", running, 0);
            chk(step == '0, "R3", "idle step", step, 0);
        end
    endtask

    task automatic t_start_metrics();
        // symbol 11 from the zero state: state 0 keeps its upper path (R6)
        begin_run("R2");
        feed(2'b11, "R6");
        chk(dec[0] == 1'b0, "R6", "dec[0] on first 11", dec[0], 0);
        // symbol 00 from the zero state: states 1 and 3 tie, upper wins (R5)
        begin_run("R2");
        feed(2'b00, "R5");
        chk(dec == 4'b0000, "R5", "tie vector on first 00", dec, 0);
    endtask

    task automatic t_clean_message(input int len);
        begin_run("R2");
        enc_st = 2'b00;
        for (int i = 0; i < len + 2; i++) begin
            logic u;
            u = (i < len) ? 1'($urandom_range(1)) : 1'b0;
            feed(encode(u), "R4");
        end
    endtask

    task automatic t_gaps();
        begin_run("R2");
        enc_st = 2'b00;
        for (int i = 0; i < 12; i++) begin
            feed(encode(1'($urandom_range(1))), "R8");
            if (i % 3 == 1) begin
                logic [TB_STEP_W-1:0] held;
                held = step;
                cyc(1'b0, 1'b0, 2'b11);
                chk(dec_valid == 1'b0, "R8", "gap dec_valid", dec_valid, 0);
                chk(step == held, "R8", "gap step", step, held);
            end
        end
    endtask

    task automatic t_collision();
        begin_run("R2");
        for (int i = 0; i < 5; i++) feed(2'($urandom_range(3)), "R3");
        cyc(1'b1, 1'b1, 2'b11);
        ref_init();
        chk(dec_valid == 1'b0, "R3", "start+symbol dec_valid", dec_valid, 0);
        chk(step == '0, "R3", "start+symbol step", step, 0);
        feed(2'b00, "R3");
        feed(2'b10, "R3");
    endtask

    task automatic t_restart();
        begin_run("R2");
        for (int i = 0; i < 30; i++) feed(2'($urandom_range(3)), "R9");
        begin_run("R9");
        enc_st = 2'b00;
        for (int i = 0; i < 20; i++) feed(encode(1'($urandom_range(1))), "R9");
    endtask

    task automatic t_noisy_long(input int len);
        int mn;
        begin_run("R2");
        for (int i = 0; i < len; i++) feed(2'($urandom_range(3)), "R7");
        mn = rpm[0];
        for (int n = 1; n < 4; n++) if (rpm[n] < mn) mn = rpm[n];
        chk(mn > 256, "R7", "reference minimum beyond metric range", mn, 257);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignored();
        t_start_metrics();
        t_clean_message(40);
        t_clean_message(60);
        t_gaps();
        t_collision();
        t_restart();
        t_noisy_long(1500);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule